// File: doc/BRIEF.md
# Power-Down Clock Output Gate

This block sits between a clock generator's raw output clocks and its output pins. It stops every output cleanly when an active-low power-down request is asserted, asks the oscillator and PLL to halt while the outputs are stopped, and brings the outputs back after a timed wake-up. Each gated output also has a static enable bit from a configuration register. A separate group of fixed outputs ignores those enable bits but still obeys power-down.

The request pin is asynchronous to every clock. It is sampled on the rising edges of a reference clock, and a power-down is accepted only when two consecutive samples are low. Every output is then released by a cell built around a level-sensitive latch that is open only while that output's raw clock is low. An output therefore finishes its current high phase and then stays low, and when it is let go again it starts with a whole high pulse. When the request is withdrawn, a counter on the reference clock runs for `WAKE_CYCLES` edges before the outputs are let go and `clk_ready` rises. An integrator sets `WAKE_CYCLES` to cover the PLL lock time within the 3 ms restart limit at the reference frequency in use.

All pins are plain control and clock signals. There is no streaming interface and no back-pressure.

Top module: `pwrdn_clk_gate`

## Requirements
- R1: While `rst_n` is low, every output clock, `osc_stop` and `clk_ready` are low. After release, `clk_ready` rises after exactly `WAKE_CYCLES` rising edges of `ref_clk`.
- R2: A power-down is accepted only when `pd_req_n` is sampled low on two consecutive `ref_clk` rising edges. `osc_stop` rises and `clk_ready` falls on the edge after the second low sample. A request that is low for one sample only has no effect.
- R3: After acceptance, each output completes its current high phase at full width and then stays low. No output edge occurs while powered down.
- R4: `osc_stop` stays high for the whole power-down. It falls on the second `ref_clk` edge after `pd_req_n` is first sampled high.
- R5: After release, all outputs stay low while the wake counter runs. `clk_ready` rises on the `WAKE_CYCLES+2`-th `ref_clk` edge counted from the first high sample, and the outputs then toggle again.
- R6: When `out_en[i]` is 0, `gated_clk[i]` is held low and does not toggle. When it is 1, that output runs.
- R7: The `fixed_clk` outputs toggle whatever the value of `out_en`, and they stop during power-down.
- R8: If a power-down is accepted on the same edge on which the wake counter expires, the power-down wins: `clk_ready` stays low and `osc_stop` rises again.
- R9: Changing enables or power state at any time produces only whole pulses. Every high pulse equals the raw clock's high phase, and every low pulse lasts at least one raw low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock that samples the request and runs the wake counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| raw_clk | input | N_GATED | Raw clocks for the outputs that have enable bits |
| raw_fixed | input | N_FIXED | Raw clocks for the fixed outputs |
| out_en | input | N_GATED | Per-output enable bits from configuration (1 = run) |
| gated_clk | output | N_GATED | Gated output clocks |
| fixed_clk | output | N_FIXED | Fixed output clocks, gated only by power-down |
| osc_stop | output | 1 | Request to stop the oscillator and PLL |
| clk_ready | output | 1 | High while the outputs are allowed to run |

## Verification
The wake counter's expiry and a fresh power-down acceptance can fall on the same reference edge. The bench provokes this by releasing the request and then driving it low again so that its second low sample lands on the edge where the countdown reaches zero. It then judges the result by requiring that `clk_ready` never rises and that `osc_stop` returns high. A second overlap, where enable bits change while a raw clock is mid-phase, is provoked by rapid enable toggling and judged by measuring every pulse width at the outputs.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;

  // Power sequencer states
  typedef enum logic [1:0] {
    PD_RUN  = 2'd0,
    PD_DOWN = 2'd1,
    PD_WAKE = 2'd2
  } pd_state_e;

endpackage

// File: rtl/pd_sampler.sv
`timescale 1ns/1ps
// Samples the asynchronous power-down request on the reference clock.
// seen: the newest sample was low. hit: the last two samples were low.
module pd_sampler (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic pd_req_n,
  output logic seen,
  output logic hit
);
  logic smp_new, smp_old;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_new <= 1'b0;
      smp_old <= 1'b0;
    end else begin
      smp_new <= ~pd_req_n;
      smp_old <= smp_new;
    end
  end

  assign seen = smp_new;
  assign hit  = smp_new & smp_old;
endmodule

// File: rtl/pd_sequencer.sv
`timescale 1ns/1ps
// Run / down / wake state machine with the wake-up delay counter.
module pd_sequencer
  import clkgate_pkg::*;
#(
  parameter int WAKE_CYCLES = 16
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic pd_req_n,
  input  logic seen,
  input  logic hit,
  output logic run_q,
  output logic stop_q
);
  localparam int CW = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WAKE_CYCLES - 1);

  pd_state_e      st, st_nx;
  logic [CW-1:0]  cnt, cnt_nx;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    unique case (st)
      PD_RUN:  if (hit) st_nx = PD_DOWN;
      PD_DOWN: if (!seen) begin
                 st_nx  = PD_WAKE;
                 cnt_nx = LOAD;
               end
      PD_WAKE: begin
                 // a fresh acceptance beats counter expiry
                 if (hit)              st_nx  = PD_DOWN;
                 else if (cnt == '0)   st_nx  = PD_RUN;
                 else                  cnt_nx = cnt - CW'(1);
               end
      default: st_nx = PD_DOWN;
    endcase
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= PD_WAKE;
      cnt    <= LOAD;
      run_q  <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      st     <= st_nx;
      cnt    <= cnt_nx;
      run_q  <= (st_nx == PD_RUN);
      stop_q <= (st_nx == PD_DOWN);
    end
  end

  // Checker counter: edges spent in the wake state
  logic [CW:0] wake_seen;
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)              wake_seen <= '0;
    else if (st == PD_WAKE)  wake_seen <= wake_seen + (CW+1)'(1);
    else                     wake_seen <= '0;
  end

  // R2: a stop request only follows two low samples of the pin
  a_r2_two_low_samples: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(stop_q) |-> (!$past(pd_req_n, 2) && !$past(pd_req_n, 3)));

  // R4: the stop request is withdrawn only after the pin was seen high
  a_r4_release_seen: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(stop_q) |-> $past(pd_req_n, 2));

  // R5: outputs are let go only after the full wake window
  a_r5_wake_length: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(run_q) |-> (wake_seen == (CW+1)'(WAKE_CYCLES)));

  // R8: no release when two low samples meet the counter expiry
  a_r8_down_wins: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(run_q) |-> !(!$past(pd_req_n, 2) && !$past(pd_req_n, 3)));
endmodule

// File: rtl/glitchfree_gate.sv
`timescale 1ns/1ps
// Clock gate: the permission is captured only while the raw clock is low,
// so a high phase is never shortened and a restart begins on a whole pulse.
module glitchfree_gate (
  input  logic clk_in,
  input  logic allow,
  output logic clk_out
);
  logic hold;

  always_latch begin
    if (!clk_in) hold <= allow;
  end

  assign clk_out = clk_in & hold;
endmodule

// File: rtl/pwrdn_clk_gate.sv
`timescale 1ns/1ps
module pwrdn_clk_gate #(
  parameter int N_GATED     = 4,
  parameter int N_FIXED     = 2,
  parameter int WAKE_CYCLES = 16
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic               pd_req_n,
  input  logic [N_GATED-1:0] raw_clk,
  input  logic [N_FIXED-1:0] raw_fixed,
  input  logic [N_GATED-1:0] out_en,
  output logic [N_GATED-1:0] gated_clk,
  output logic [N_FIXED-1:0] fixed_clk,
  output logic               osc_stop,
  output logic               clk_ready
);
  logic seen, hit, run_q, stop_q;

  pd_sampler u_smp (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .pd_req_n (pd_req_n),
    .seen     (seen),
    .hit      (hit)
  );

  pd_sequencer #(.WAKE_CYCLES(WAKE_CYCLES)) u_seq (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .pd_req_n (pd_req_n),
    .seen     (seen),
    .hit      (hit),
    .run_q    (run_q),
    .stop_q   (stop_q)
  );

  assign osc_stop  = stop_q;
  assign clk_ready = run_q;

  for (genvar i = 0; i < N_GATED; i++) begin : g_gated
    glitchfree_gate u_gate (
      .clk_in  (raw_clk[i]),
      .allow   (run_q & out_en[i]),
      .clk_out (gated_clk[i])
    );
  end

  for (genvar j = 0; j < N_FIXED; j++) begin : g_fixed
    glitchfree_gate u_gate (
      .clk_in  (raw_fixed[j]),
      .allow   (run_q),
      .clk_out (fixed_clk[j])
    );
  end
endmodule

// File: tb/tb_pwrdn_clk_gate.sv
`timescale 1ns/100ps
module tb_pwrdn_clk_gate;
  localparam int NG = 4, NF = 2, NT = NG + NF, WAKE = 16;

  logic ref_clk = 1'b0, rst_n = 1'b0, pd_req_n = 1'b1;
  logic [NG-1:0] raw_clk, out_en, gated_clk;
  logic [NF-1:0] raw_fixed, fixed_clk;
  logic osc_stop, clk_ready;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 ref_clk = ~ref_clk;   // 200 MHz

  pwrdn_clk_gate #(.N_GATED(NG), .N_FIXED(NF), .WAKE_CYCLES(WAKE)) dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .pd_req_n(pd_req_n),
    .raw_clk(raw_clk), .raw_fixed(raw_fixed), .out_en(out_en),
    .gated_clk(gated_clk), .fixed_clk(fixed_clk),
    .osc_stop(osc_stop), .clk_ready(clk_ready));

  function automatic real half_of(int g);
    return (g < NG) ? 3.0 + 2.0 * g : 4.0 + 4.0 * (g - NG);
  endfunction

  // raw clock sources, edges at .3 ns offsets away from reference edges
  for (genvar g = 0; g < NT; g++) begin : src
    logic r = 1'b0;
    initial begin
      #0.3;
      forever #(half_of(g)) r = ~r;
    end
    if (g < NG) begin : gs
      assign raw_clk[g] = r;
    end else begin : fs
      assign raw_fixed[g-NG] = r;
    end
  end

  // pulse-width and edge monitors on every output
  wire [NT-1:0] outs = {fixed_clk, gated_clk};
  int unsigned edge_cnt [NT];
  int unsigned bad_cnt  [NT];
  for (genvar g = 0; g < NT; g++) begin : mon
    realtime t_rise, t_fall;
    bit seen_r, seen_f;
    int unsigned e, b_r, b_f;
    always @(posedge outs[g]) begin
      if (seen_f && ($realtime - t_fall) < half_of(g) - 0.05) b_r++;
      t_rise = $realtime; seen_r = 1; e++;
    end
    always @(negedge outs[g]) begin
      if (seen_r && ((($realtime - t_rise) > half_of(g) + 0.05) ||
                     (($realtime - t_rise) < half_of(g) - 0.05))) b_f++;
      t_fall = $realtime; seen_f = 1;
    end
    assign edge_cnt[g] = e;
    assign bad_cnt[g]  = b_r + b_f;
  end

  int unsigned snap [NT];

  function automatic int unsigned total_bad();
    int unsigned s = 0;
    for (int i = 0; i < NT; i++) s += bad_cnt[i];
    return s;
  endfunction

  task automatic take_snap();
    for (int i = 0; i < NT; i++) snap[i] = edge_cnt[i];
  endtask

  function automatic int unsigned new_edges(int i);
    return edge_cnt[i] - snap[i];
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge ref_clk);
    @(negedge ref_clk);
  endtask

  task automatic t_reset();
    out_en = '1;
    #50;
    check(clk_ready == 0 && osc_stop == 0, "R1", "status in reset", {clk_ready, osc_stop}, 0);
    check(outs == '0, "R1", "outputs in reset", outs, 0);
    take_snap();
    #40;
    for (int i = 0; i < NT; i++)
      check(new_edges(i) == 0, "R1", $sformatf("edges in reset out%0d", i), new_edges(i), 0);
    @(negedge ref_clk) rst_n = 1'b1;
    for (int k = 1; k <= WAKE; k++) begin
      step();
      if (k == WAKE - 1) check(clk_ready == 0, "R1", "ready one edge early", clk_ready, 0);
      if (k == WAKE)     check(clk_ready == 1, "R1", "ready after wake count", clk_ready, 1);
    end
  endtask

  task automatic t_run_all();
    #20; take_snap(); #200;
    for (int i = 0; i < NT; i++)
      check(new_edges(i) > 10, "R6", $sformatf("running out%0d", i), new_edges(i), 11);
    check(total_bad() == 0, "R9", "pulse widths while running", total_bad(), 0);
  endtask

  task automatic t_glitch_pd();
    @(negedge ref_clk) pd_req_n = 1'b0;
    @(negedge ref_clk) pd_req_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      check(osc_stop == 0 && clk_ready == 1, "R2", "single low sample ignored",
            {osc_stop, clk_ready}, 1);
    end
  endtask

  task automatic t_powerdown();
    @(negedge ref_clk) pd_req_n = 1'b0;
    step(); step();
    check(osc_stop == 0 && clk_ready == 1, "R2", "not yet accepted after two edges",
          {osc_stop, clk_ready}, 1);
    step();
    check(osc_stop == 1 && clk_ready == 0, "R2", "accepted on third edge",
          {osc_stop, clk_ready}, 2);
    #30; take_snap(); #200;
    for (int i = 0; i < NT; i++)
      check(new_edges(i) == 0, "R3", $sformatf("no edges while down out%0d", i), new_edges(i), 0);
    check(outs == '0, "R3", "outputs low while down", outs, 0);
    check(total_bad() == 0, "R3", "last high phase full width", total_bad(), 0);
    check(osc_stop == 1, "R4", "stop held while down", osc_stop, 1);
  endtask

  task automatic t_wakeup();
    @(negedge ref_clk) pd_req_n = 1'b1;
    take_snap();
    for (int k = 1; k <= WAKE + 2; k++) begin
      step();
      if (k == 1) check(osc_stop == 1, "R4", "stop held one edge after release", osc_stop, 1);
      if (k == 2) check(osc_stop == 0, "R4", "stop dropped on second edge", osc_stop, 0);
      if (k == WAKE + 1) begin
        check(clk_ready == 0, "R5", "ready low before wake ends", clk_ready, 0);
        for (int i = 0; i < NT; i++)
          check(new_edges(i) == 0, "R5", $sformatf("quiet during wake out%0d", i), new_edges(i), 0);
      end
      if (k == WAKE + 2) check(clk_ready == 1, "R5", "ready at wake end", clk_ready, 1);
    end
    take_snap(); #100;
    for (int i = 0; i < NT; i++)
      check(new_edges(i) > 0, "R5", $sformatf("restart out%0d", i), new_edges(i), 1);
    check(total_bad() == 0, "R5", "restart pulses whole", total_bad(), 0);
  endtask

  task automatic t_enable();
    @(negedge ref_clk) out_en = 4'b0101;
    #40; take_snap(); #200;
    check(new_edges(1) == 0 && new_edges(3) == 0, "R6", "disabled outputs quiet",
          new_edges(1) + new_edges(3), 0);
    check(gated_clk[1] == 0 && gated_clk[3] == 0, "R6", "disabled outputs low",
          {gated_clk[3], gated_clk[1]}, 0);
    check(new_edges(0) > 0 && new_edges(2) > 0, "R6", "enabled outputs run",
          new_edges(0) > 0 && new_edges(2) > 0, 1);
    out_en = '0;
    #40; take_snap(); #200;
    check(new_edges(NG) > 0 && new_edges(NG+1) > 0, "R7", "fixed outputs ignore enables",
          new_edges(NG) > 0 && new_edges(NG+1) > 0, 1);
    for (int i = 0; i < NG; i++)
      check(new_edges(i) == 0, "R6", $sformatf("all disabled out%0d", i), new_edges(i), 0);
    for (int k = 0; k < 30; k++) begin
      out_en = 4'(k * 5 + 3);
      #7;
    end
    out_en = '1;
    take_snap(); #100;
    check(total_bad() == 0, "R9", "whole pulses across enable churn", total_bad(), 0);
    for (int i = 0; i < NG; i++)
      check(new_edges(i) > 0, "R6", $sformatf("re-enabled out%0d", i), new_edges(i), 1);
  endtask

  task automatic t_abort();
    @(negedge ref_clk) pd_req_n = 1'b0;
    step(); step(); step();
    check(osc_stop == 1, "R8", "entered power-down", osc_stop, 1);
    @(negedge ref_clk) pd_req_n = 1'b1;
    for (int k = 1; k <= WAKE - 1; k++) step();
    pd_req_n = 1'b0;
    for (int k = WAKE; k <= WAKE + 3; k++) begin
      step();
      check(clk_ready == 0, "R8", $sformatf("no release at edge %0d", k), clk_ready, 0);
    end
    check(osc_stop == 1, "R8", "back in power-down", osc_stop, 1);
    take_snap(); #100;
    check(clk_ready == 0, "R8", "stays down", clk_ready, 0);
    check(outs == '0, "R8", "outputs stay low", outs, 0);
    t_wakeup();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    out_en = '1;
    t_reset();
    t_run_all();
    t_glitch_pd();
    t_powerdown();
    t_wakeup();
    t_enable();
    t_abort();
    t_run_all();
    finish_run();
  end

  initial begin
    #200000;
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule